// File: doc/BRIEF.md
# Serial-Loaded Configuration Register Bank

This block takes an asynchronous serial receive line (8 data bits, no parity, one stop bit) and turns the byte stream into writes on a small, sparse, write-only set of configuration fields. A write is always a pair of bytes. The first byte names the target register and the second byte carries the value. The decoded fields drive a signal-generation core that sits downstream and is not part of this block: an enable bit, two mute bits, a 5-bit satellite selector, an 8-bit Doppler code, a 16-bit code phase and a 3-bit amplitude shift.

The receiver synchronises the line and looks for a falling edge. It confirms the start bit half a bit period later and then samples each data bit in the middle of its period. Finally it checks that the stop bit is high. If a frame ends with a low stop bit, the frame is dropped and the pairing logic goes back to expecting an address. At the default clock of 16.368 MHz and 115200 baud, one bit lasts 142 clocks. The bit period is a parameter.

Top module: `serial_cfg_bank`

## Requirements
- R1: While idle the line is high. A low level is taken as a start bit only if it is still low CLKS_PER_BIT/2 clocks after it is first seen. A shorter low pulse is ignored and causes no write.
- R2: Each frame carries 8 data bits, least significant bit first. Each bit lasts CLKS_PER_BIT clocks and is sampled in the middle of its period.
- R3: A frame whose stop bit is sampled low is discarded and returns the pairing logic to expecting an address byte. The receiver then waits for the line to go high before it looks for a new start bit.
- R4: Good bytes alternate between address and data, starting with an address after reset. A register changes only when a data byte arrives, and after each data byte the next byte is an address again.
- R5: Address 0x00 is the control register. Data bit 0 drives `core_en`, bit 4 drives `noise_off` and bit 6 drives `signal_off`. Every other bit of the byte is ignored.
- R6: Address 0x02 loads `sat_id` from data bits 4:0. Bits 7:5 are ignored.
- R7: Address 0x03 loads all 8 data bits into `doppler`.
- R8: Address 0x04 loads `code_phase[7:0]` and address 0x05 loads `code_phase[15:8]`. Each write leaves the other byte untouched.
- R9: Address 0x06 loads `snr_shift` from data bits 2:0. Bits 7:3 are ignored.
- R10: A data byte sent to any other address (0x01 or 0x07 to 0xFF) is consumed as data and changes no output.
- R11: An active-low reset clears every output field to zero and leaves the pairing logic expecting an address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial receive line, idle high |
| core_en | output | 1 | Control bit: core enable |
| noise_off | output | 1 | Control bit: mute noise source |
| signal_off | output | 1 | Control bit: mute signal |
| sat_id | output | 5 | Satellite code selector |
| doppler | output | 8 | Doppler frequency code |
| code_phase | output | 16 | Code phase, high and low bytes |
| snr_shift | output | 3 | Right-shift count applied to the signal |

## Verification
The bench builds the block with CLKS_PER_BIT = 8 and two synchroniser stages. A whole two-byte write then takes about 160 clocks instead of about 2840. That makes it affordable to run many writes per test: every mapped address, several unmapped ones, framing errors on both the address byte and the data byte, and a start glitch shorter than half a bit. With the short bit period, the half-bit confirmation window is only four clocks wide. A glitch of two clocks therefore tests the start-bit rejection close to its margin.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

  localparam int BYTE_W      = 8;
  localparam int SAT_W       = 5;
  localparam int SNR_W       = 3;
  localparam int PHASE_BYTES = 2;
  localparam int PHASE_W     = PHASE_BYTES * BYTE_W;

  // register addresses (decoded by the sequencer/regfile pair)
  localparam logic [BYTE_W-1:0] ADR_CTRL  = 8'h00;
  localparam logic [BYTE_W-1:0] ADR_SAT   = 8'h02;
  localparam logic [BYTE_W-1:0] ADR_DOP   = 8'h03;
  localparam logic [BYTE_W-1:0] ADR_PH_LO = 8'h04;
  localparam logic [BYTE_W-1:0] ADR_SNR   = 8'h06;

  // control byte bit positions
  localparam int BIT_EN    = 0;
  localparam int BIT_NOISE = 4;
  localparam int BIT_SIG   = 6;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAIT_HIGH
  } rx_state_t;

  typedef enum logic {
    SQ_ADDR,
    SQ_DATA
  } seq_state_t;

  typedef struct packed {
    logic               core_en;
    logic               noise_off;
    logic               signal_off;
    logic [SAT_W-1:0]   sat_id;
    logic [BYTE_W-1:0]  doppler;
    logic [PHASE_W-1:0] phase;
    logic [SNR_W-1:0]   snr;
  } cfg_t;

  // true when the address selects a physical register
  function automatic logic addr_mapped(input logic [BYTE_W-1:0] a);
    return (a == ADR_CTRL) || (a == ADR_SAT) || (a == ADR_DOP) ||
           (a >= ADR_PH_LO && a < ADR_PH_LO + BYTE_W'(PHASE_BYTES)) ||
           (a == ADR_SNR);
  endfunction

  // the three retained control bits, packed en/noise/sig
  function automatic logic [2:0] ctrl_pick(input logic [BYTE_W-1:0] d);
    return {d[BIT_EN], d[BIT_NOISE], d[BIT_SIG]};
  endfunction

endpackage

// File: rtl/sercfg_uart_rx.sv
module sercfg_uart_rx
  import sercfg_pkg::*;
#(
  parameter int CLKS_PER_BIT = 142,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_in,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              frame_err
);

  localparam int CNT_W = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int HALF  = CLKS_PER_BIT / 2;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF - 1);
  localparam int IDX_W = $clog2(BYTE_W);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  rx_state_t              state_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [IDX_W-1:0]       idx_q;
  logic [BYTE_W-1:0]      shift_q;
  logic                   valid_q;
  logic                   err_q;

  // metastability synchroniser, reset to idle level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
  end
  assign rx_s = sync_q[SYNC_STAGES-1];

  logic tick_full;
  logic tick_half;
  assign tick_full = (cnt_q == CNT_FULL);
  assign tick_half = (cnt_q == CNT_HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      unique case (state_q)
        RX_IDLE: begin
          cnt_q <= '0;
          if (!rx_s) state_q <= RX_START;
        end
        RX_START: begin
          if (tick_half) begin
            cnt_q <= '0;
            idx_q <= '0;
            state_q <= rx_s ? RX_IDLE : RX_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (tick_full) begin
            cnt_q   <= '0;
            shift_q <= {rx_s, shift_q[BYTE_W-1:1]};
            idx_q   <= idx_q + 1'b1;
            if (idx_q == IDX_W'(BYTE_W - 1)) state_q <= RX_STOP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (tick_full) begin
            cnt_q <= '0;
            if (rx_s) begin
              valid_q <= 1'b1;
              state_q <= RX_IDLE;
            end else begin
              err_q   <= 1'b1;
              state_q <= RX_WAIT_HIGH;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_WAIT_HIGH: begin
          cnt_q <= '0;
          if (rx_s) state_q <= RX_IDLE;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign byte_valid = valid_q;
  assign byte_data  = shift_q;
  assign frame_err  = err_q;

endmodule

// File: rtl/sercfg_sequencer.sv
module sercfg_sequencer
  import sercfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              frame_err,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              in_data_phase
);

  seq_state_t        state_q;
  logic [BYTE_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_ADDR;
      addr_q  <= '0;
    end else if (frame_err) begin
      state_q <= SQ_ADDR;
    end else if (byte_valid) begin
      if (state_q == SQ_ADDR) begin
        addr_q  <= byte_data;
        state_q <= SQ_DATA;
      end else begin
        state_q <= SQ_ADDR;
      end
    end
  end

  assign in_data_phase = (state_q == SQ_DATA);
  assign wr_stb        = byte_valid && in_data_phase;
  assign wr_addr       = addr_q;
  assign wr_data       = byte_data;

endmodule

// File: rtl/sercfg_regfile.sv
module sercfg_regfile
  import sercfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output cfg_t              cfg
);

  logic [2:0]         ctrl_q;
  logic [SAT_W-1:0]   sat_q;
  logic [BYTE_W-1:0]  dop_q;
  logic [SNR_W-1:0]   snr_q;
  logic [PHASE_W-1:0] phase_w;

  logic hit_ctrl, hit_sat, hit_dop, hit_snr;
  assign hit_ctrl = wr_stb && (wr_addr == ADR_CTRL);
  assign hit_sat  = wr_stb && (wr_addr == ADR_SAT);
  assign hit_dop  = wr_stb && (wr_addr == ADR_DOP);
  assign hit_snr  = wr_stb && (wr_addr == ADR_SNR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sat_q  <= '0;
      dop_q  <= '0;
      snr_q  <= '0;
    end else begin
      if (hit_ctrl) ctrl_q <= ctrl_pick(wr_data);
      if (hit_sat)  sat_q  <= wr_data[SAT_W-1:0];
      if (hit_dop)  dop_q  <= wr_data;
      if (hit_snr)  snr_q  <= wr_data[SNR_W-1:0];
    end
  end

  // one byte lane per phase byte, consecutive addresses from ADR_PH_LO
  for (genvar i = 0; i < PHASE_BYTES; i++) begin : g_phase
    logic lane_hit;
    logic [BYTE_W-1:0] lane_q;
    assign lane_hit = wr_stb && (wr_addr == ADR_PH_LO + BYTE_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lane_q <= '0;
      else if (lane_hit) lane_q <= wr_data;
    end
    assign phase_w[i*BYTE_W +: BYTE_W] = lane_q;
  end

  assign cfg.core_en    = ctrl_q[2];
  assign cfg.noise_off  = ctrl_q[1];
  assign cfg.signal_off = ctrl_q[0];
  assign cfg.sat_id     = sat_q;
  assign cfg.doppler    = dop_q;
  assign cfg.phase      = phase_w;
  assign cfg.snr        = snr_q;

endmodule

// File: rtl/serial_cfg_bank.sv
module serial_cfg_bank
  import sercfg_pkg::*;
#(
  parameter int CLKS_PER_BIT = 142,
  parameter int SYNC_STAGES  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_in,
  output logic         core_en,
  output logic         noise_off,
  output logic         signal_off,
  output logic [4:0]   sat_id,
  output logic [7:0]   doppler,
  output logic [15:0]  code_phase,
  output logic [2:0]   snr_shift
);

  // named internal events, observed by the bound checker
  logic              byte_valid;
  logic [BYTE_W-1:0] byte_data;
  logic              frame_err;
  logic              wr_stb;
  logic [BYTE_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_data;
  logic              seq_in_data;
  cfg_t              cfg;

  sercfg_uart_rx #(
    .CLKS_PER_BIT (CLKS_PER_BIT),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_in      (rx_in),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .frame_err  (frame_err)
  );

  sercfg_sequencer u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .byte_valid    (byte_valid),
    .byte_data     (byte_data),
    .frame_err     (frame_err),
    .wr_stb        (wr_stb),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .in_data_phase (seq_in_data)
  );

  sercfg_regfile u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg     (cfg)
  );

  assign core_en    = cfg.core_en;
  assign noise_off  = cfg.noise_off;
  assign signal_off = cfg.signal_off;
  assign sat_id     = cfg.sat_id;
  assign doppler    = cfg.doppler;
  assign code_phase = cfg.phase;
  assign snr_shift  = cfg.snr;

endmodule

// File: rtl/serial_cfg_bank_checker.sv
module serial_cfg_bank_checker
  import sercfg_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        byte_valid,
  input logic        frame_err,
  input logic        wr_stb,
  input logic [7:0]  wr_addr,
  input logic [7:0]  wr_data,
  input logic        seq_in_data,
  input logic        core_en,
  input logic        noise_off,
  input logic        signal_off,
  input logic [4:0]  sat_id,
  input logic [7:0]  doppler,
  input logic [15:0] code_phase,
  input logic [2:0]  snr_shift
);

  logic [34:0] fields;
  assign fields = {core_en, noise_off, signal_off, sat_id, doppler, code_phase, snr_shift};

  // R3: a frame is either good or bad, never both
  p_good_or_bad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_valid && frame_err));

  // R3: framing error sends the pairing logic back to address
  p_err_resets_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !seq_in_data);

  // R4: no write strobe, no field change
  p_hold_without_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(fields));

  // R4: after a data byte, the next byte is an address
  p_back_to_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !seq_in_data);

  // R5: control bits land on their outputs
  p_ctrl_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr == 8'h00) |=>
      (core_en == $past(wr_data[0])) && (noise_off == $past(wr_data[4])) &&
      (signal_off == $past(wr_data[6])));

  // R6: satellite selector keeps the low five bits
  p_sat_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr == 8'h02) |=> sat_id == $past(wr_data[4:0]));

  // R8: writing the low phase byte keeps the high byte
  p_phase_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr == 8'h04) |=>
      (code_phase[7:0] == $past(wr_data)) && $stable(code_phase[15:8]));

  // R9: shift count keeps the low three bits
  p_snr_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr == 8'h06) |=> snr_shift == $past(wr_data[2:0]));

  // R10: unmapped addresses leave every field alone
  p_unmapped_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !addr_mapped(wr_addr)) |=> $stable(fields));

endmodule

bind serial_cfg_bank serial_cfg_bank_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .byte_valid  (byte_valid),
  .frame_err   (frame_err),
  .wr_stb      (wr_stb),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .seq_in_data (seq_in_data),
  .core_en     (core_en),
  .noise_off   (noise_off),
  .signal_off  (signal_off),
  .sat_id      (sat_id),
  .doppler     (doppler),
  .code_phase  (code_phase),
  .snr_shift   (snr_shift)
);

// File: tb/test_serial_cfg_bank.sv
module test_serial_cfg_bank;

  localparam int CPB = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_in = 1'b1;
  logic        core_en, noise_off, signal_off;
  logic [4:0]  sat_id;
  logic [7:0]  doppler;
  logic [15:0] code_phase;
  logic [2:0]  snr_shift;

  always #2 clk = ~clk;

  serial_cfg_bank #(.CLKS_PER_BIT(CPB), .SYNC_STAGES(2)) i_serial_cfg_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_in      (rx_in),
    .core_en    (core_en),
    .noise_off  (noise_off),
    .signal_off (signal_off),
    .sat_id     (sat_id),
    .doppler    (doppler),
    .code_phase (code_phase),
    .snr_shift  (snr_shift)
  );

  typedef struct {
    string       req;
    logic [34:0] exp;
  } item_t;

  item_t q[$];
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // bench model of the register map
  logic        m_en = 0, m_noise = 0, m_sig = 0;
  logic [4:0]  m_sat = 0;
  logic [7:0]  m_dop = 0;
  logic [15:0] m_ph = 0;
  logic [2:0]  m_snr = 0;

  function automatic logic [34:0] model_snap();
    return {m_en, m_noise, m_sig, m_sat, m_dop, m_ph, m_snr};
  endfunction

  function automatic logic [34:0] dut_snap();
    return {core_en, noise_off, signal_off, sat_id, doppler, code_phase, snr_shift};
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h00) begin m_en = d[0]; m_noise = d[4]; m_sig = d[6]; end
    else if (a == 8'h02) m_sat = d[4:0];
    else if (a == 8'h03) m_dop = d;
    else if (a == 8'h04) m_ph[7:0] = d;
    else if (a == 8'h05) m_ph[15:8] = d;
    else if (a == 8'h06) m_snr = d[2:0];
  endtask

  task automatic hold_bit(input logic v);
    rx_in = v;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit good_stop);
    hold_bit(1'b0);
    for (int i = 0; i < 8; i++) hold_bit(b[i]);
    hold_bit(good_stop);
    if (!good_stop) hold_bit(1'b1);
  endtask

  task automatic push(input string req);
    item_t it;
    it.req = req;
    it.exp = model_snap();
    q.push_back(it);
  endtask

  // driver: one complete register write, expectation queued afterwards
  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string req);
    send_byte(a, 1'b1);
    send_byte(d, 1'b1);
    model_write(a, d);
    push(req);
  endtask

  // monitor: compare the outputs once per queued expectation
  initial begin
    forever begin
      item_t it;
      wait (q.size() != 0);
      @(negedge clk);
      it = q.pop_front();
      n_tests++;
      if (dut_snap() !== it.exp) begin
        n_fail++;
        $display("FAIL %s: fields actual=%h expected=%h", it.req, dut_snap(), it.exp);
      end
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R11: all fields zero while and after reset
    n_tests++;
    if (dut_snap() !== 35'h0) begin
      n_fail++;
      $display("FAIL R11 reset: actual=%h expected=%h", dut_snap(), 35'h0);
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: a 2-clock low pulse must not start a frame
    rx_in = 1'b0;
    repeat (2) @(negedge clk);
    rx_in = 1'b1;
    repeat (3 * CPB) @(negedge clk);
    push("R1 glitch ignored");
    wr(8'h02, 8'h0B, "R1 write after glitch");

    // R5: control bits, mapped and ignored positions
    wr(8'h00, 8'hFF, "R5 ctrl all ones");
    wr(8'h00, 8'hAE, "R5 ctrl only ignored bits set");
    wr(8'h00, 8'h51, "R5 ctrl en+noise+sig");
    wr(8'h00, 8'h10, "R5 ctrl noise only");

    // R6: satellite id keeps low 5 bits
    wr(8'h02, 8'hFF, "R6 sat id truncation");
    // R7 / R2: Doppler full byte, asymmetric patterns check bit order
    wr(8'h03, 8'hB0, "R7 doppler 0xB0");
    wr(8'h03, 8'h01, "R2 lsb-first single bit");
    wr(8'h03, 8'h80, "R2 msb single bit");
    // R8: phase bytes independently
    wr(8'h04, 8'h34, "R8 phase low");
    wr(8'h05, 8'h12, "R8 phase high");
    wr(8'h05, 8'hAB, "R8 high keeps low");
    // R9: shift count low 3 bits
    wr(8'h06, 8'hFD, "R9 snr truncation");
    // R10: unmapped addresses
    wr(8'h01, 8'hFF, "R10 addr 0x01 dropped");
    wr(8'h07, 8'h55, "R10 addr 0x07 dropped");
    wr(8'hFF, 8'hAA, "R10 addr 0xFF dropped");

    // R3: bad stop on an address byte, then a clean pair
    send_byte(8'h02, 1'b0);
    wr(8'h03, 8'h77, "R3 bad address frame discarded");
    // R3 / R4: bad stop on a data byte leaves fields and re-arms address
    send_byte(8'h03, 1'b1);
    send_byte(8'h11, 1'b0);
    push("R3 bad data frame no write");
    wr(8'h06, 8'h02, "R4 next byte is an address");
    // R4: back-to-back pairs stay aligned
    wr(8'h04, 8'hC3, "R4 pair alignment a");
    wr(8'h00, 8'h01, "R4 pair alignment b");

    wait (q.size() == 0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule